// File: doc/BRIEF.md
# Raw Pixel Black Level and Digital Gain Conditioner

This block conditions a stream of raw 10-bit sensor pixels before and after a separate correction stage. On the way in, it takes a programmable black offset off each pixel so that sensor black becomes code zero, never going below zero. It then multiplies the result by a programmable digital gain between x1 and x8, saturating at full scale. At the gain output, a register can replace the conditioned stream with a generated pattern: a horizontal ramp, an inverted ramp or a solid code.

The conditioned stream leaves through a bypass port (`mid_*`) that feeds an external correction stage, such as lens shading compensation. The corrected stream returns on `corr_*`. The block adds a second programmable black level to it, saturating at full scale, and drives the result on `out_*`. All configuration is sampled only at frame boundaries, so a frame is always processed with one consistent setting.

Top module: `pc_cond`

## Requirements
- R1: After reset, `mid_valid` and `out_valid` are 0.
- R2: With the pattern off, the subtracted value is `in_data - black_sub` when `in_data > black_sub`, and 0 otherwise (no wrap).
- R3: The gain code is unsigned fixed point with 5 fractional bits (32 = x1.0). The conditioned value is `(sub * gain) >> 5`, truncated, and is limited to 1023.
- R4: A gain code below 32 is treated as 32, and a gain code above 256 is treated as 256 (x8.0).
- R5: Pattern mode code 0 means off; 1 gives the column index; 2 gives `cfg_tp_value`; 3 gives 1023 minus the column index. The column index is 0 on a pixel flagged `in_sol`, goes up by one on each later valid pixel, and wraps modulo 1024. While a pattern is on, `in_data` has no effect.
- R6: The front settings (`cfg_black_sub`, `cfg_gain`, `cfg_tp_mode`, `cfg_tp_value`) are captured on a valid pixel with `in_sof` set, and apply from that pixel on. Changes at any other time have no effect until the next such pixel.
- R7: `mid_valid`, `mid_sof` and `mid_data` appear exactly one cycle after the input pixel.
- R8: `out_data` = min(`corr_data` + black_add, 1023). `out_valid` and `out_sof` follow `corr_valid` and `corr_sof` one cycle later.
- R9: `cfg_black_add` is captured on a valid corrected pixel with `corr_sof` set. Until the first such pixel after reset, the added level is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Input pixel valid |
| in_sof | input | 1 | First pixel of a frame |
| in_sol | input | 1 | First pixel of a line |
| in_data | input | 10 | Raw pixel |
| cfg_black_sub | input | 10 | Black level removed before gain |
| cfg_gain | input | 9 | Digital gain, 5 fractional bits |
| cfg_black_add | input | 10 | Black level added after correction |
| cfg_tp_mode | input | 2 | Pattern select, 0 = off |
| cfg_tp_value | input | 10 | Solid pattern code |
| mid_valid | output | 1 | Conditioned pixel valid |
| mid_sof | output | 1 | Conditioned frame start |
| mid_data | output | 10 | Conditioned pixel to correction stage |
| corr_valid | input | 1 | Corrected pixel valid |
| corr_sof | input | 1 | Corrected frame start |
| corr_data | input | 10 | Corrected pixel |
| out_valid | output | 1 | Output pixel valid |
| out_sof | output | 1 | Output frame start |
| out_data | output | 10 | Final pixel |

## Verification
A stale or corrupted frame setting shows up as a wrong value on the very next pixel, and on every pixel after it up to the next frame start. The sweeps therefore compare every pixel, and they change the settings in the middle of frames. A column counter that drifts first shows up in ramp mode, one cycle later on `mid_data`. A test line longer than 1024 pixels checks the wrap. Errors in the saturation and clamp paths only appear near the limits, so the gain, black and pixel sweeps are built to cross both ends of each range.

// File: rtl/pc_pkg.sv
package pc_pkg;
    typedef enum logic [1:0] {
        TP_OFF      = 2'd0,
        TP_RAMP     = 2'd1,
        TP_SOLID    = 2'd2,
        TP_RAMP_INV = 2'd3
    } tp_mode_e;
endpackage

// File: rtl/pc_scale.sv
module pc_scale #(
    parameter int DW    = 10,
    parameter int GW    = 9,
    parameter int GFRAC = 5
) (
    input  logic [DW-1:0] pix,
    input  logic [DW-1:0] black,
    input  logic [GW-1:0] gain,
    output logic [DW-1:0] result
);
    localparam int PW = DW + GW;
    localparam logic [GW-1:0] GMIN = GW'(1 << GFRAC);
    localparam logic [GW-1:0] GMAX = GW'(8 << GFRAC);
    localparam logic [PW-1:0] MAXV = PW'((1 << DW) - 1);

    logic [DW-1:0] sub;
    logic [GW-1:0] gain_c;
    logic [PW-1:0] prod;
    logic [PW-1:0] scaled;

    always_comb begin
        sub    = (pix > black) ? (pix - black) : '0;
        gain_c = (gain < GMIN) ? GMIN : ((gain > GMAX) ? GMAX : gain);
        prod   = PW'(sub) * PW'(gain_c);
        scaled = prod >> GFRAC;
        result = (scaled > MAXV) ? MAXV[DW-1:0] : scaled[DW-1:0];
    end
endmodule

// File: rtl/pc_front.sv
module pc_front #(
    parameter int DW    = 10,
    parameter int GW    = 9,
    parameter int GFRAC = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          in_sof,
    input  logic          in_sol,
    input  logic [DW-1:0] in_data,
    input  logic [DW-1:0] cfg_black_sub,
    input  logic [GW-1:0] cfg_gain,
    input  logic [1:0]    cfg_tp_mode,
    input  logic [DW-1:0] cfg_tp_value,
    output logic          mid_valid,
    output logic          mid_sof,
    output logic [DW-1:0] mid_data
);
    import pc_pkg::*;

    localparam logic [DW-1:0] MAXV = DW'((1 << DW) - 1);

    typedef struct packed {
        logic [DW-1:0] bs;
        logic [GW-1:0] gain;
        tp_mode_e      tp;
        logic [DW-1:0] tpv;
        logic [DW-1:0] col;
        logic          vld;
        logic          sof;
        logic [DW-1:0] data;
    } front_t;

    front_t st_d, st_q;

    logic          load;
    logic [DW-1:0] bs_e;
    logic [GW-1:0] gain_e;
    tp_mode_e      tp_e;
    logic [DW-1:0] tpv_e;
    logic [DW-1:0] col_e;
    logic [DW-1:0] scaled;

    assign load   = in_valid & in_sof;
    assign bs_e   = load ? cfg_black_sub : st_q.bs;
    assign gain_e = load ? cfg_gain : st_q.gain;
    assign tp_e   = load ? tp_mode_e'(cfg_tp_mode) : st_q.tp;
    assign tpv_e  = load ? cfg_tp_value : st_q.tpv;
    assign col_e  = in_sol ? '0 : st_q.col;

    pc_scale #(.DW(DW), .GW(GW), .GFRAC(GFRAC)) u_scale (
        .pix    (in_data),
        .black  (bs_e),
        .gain   (gain_e),
        .result (scaled)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        st_d.sof = load;
        if (load) begin
            st_d.bs   = cfg_black_sub;
            st_d.gain = cfg_gain;
            st_d.tp   = tp_mode_e'(cfg_tp_mode);
            st_d.tpv  = cfg_tp_value;
        end
        if (in_valid) begin
            st_d.col = col_e + 1'b1;
            unique case (tp_e)
                TP_OFF:      st_d.data = scaled;
                TP_RAMP:     st_d.data = col_e;
                TP_SOLID:    st_d.data = tpv_e;
                TP_RAMP_INV: st_d.data = MAXV - col_e;
                default:     st_d.data = scaled;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.gain <= GW'(1 << GFRAC);
            st_q.tp   <= TP_OFF;
        end else begin
            st_q <= st_d;
        end
    end

    assign mid_valid = st_q.vld;
    assign mid_sof   = st_q.sof;
    assign mid_data  = st_q.data;
endmodule

// File: rtl/pc_back.sv
module pc_back #(
    parameter int DW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          corr_valid,
    input  logic          corr_sof,
    input  logic [DW-1:0] corr_data,
    input  logic [DW-1:0] cfg_black_add,
    output logic          out_valid,
    output logic          out_sof,
    output logic [DW-1:0] out_data
);
    localparam logic [DW:0] MAXV = (DW+1)'((1 << DW) - 1);

    typedef struct packed {
        logic [DW-1:0] add;
        logic          vld;
        logic          sof;
        logic [DW-1:0] data;
    } back_t;

    back_t st_d, st_q;

    logic          load;
    logic [DW-1:0] add_e;
    logic [DW:0]   sum;

    assign load  = corr_valid & corr_sof;
    assign add_e = load ? cfg_black_add : st_q.add;
    assign sum   = {1'b0, corr_data} + {1'b0, add_e};

    always_comb begin
        st_d     = st_q;
        st_d.vld = corr_valid;
        st_d.sof = load;
        if (load) st_d.add = cfg_black_add;
        if (corr_valid) st_d.data = (sum > MAXV) ? MAXV[DW-1:0] : sum[DW-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign out_sof   = st_q.sof;
    assign out_data  = st_q.data;
endmodule

// File: rtl/pc_cond.sv
module pc_cond #(
    parameter int DW    = 10,
    parameter int GW    = 9,
    parameter int GFRAC = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          in_sof,
    input  logic          in_sol,
    input  logic [DW-1:0] in_data,
    input  logic [DW-1:0] cfg_black_sub,
    input  logic [GW-1:0] cfg_gain,
    input  logic [DW-1:0] cfg_black_add,
    input  logic [1:0]    cfg_tp_mode,
    input  logic [DW-1:0] cfg_tp_value,
    output logic          mid_valid,
    output logic          mid_sof,
    output logic [DW-1:0] mid_data,
    input  logic          corr_valid,
    input  logic          corr_sof,
    input  logic [DW-1:0] corr_data,
    output logic          out_valid,
    output logic          out_sof,
    output logic [DW-1:0] out_data
);
    pc_front #(.DW(DW), .GW(GW), .GFRAC(GFRAC)) u_front (
        .clk           (clk),
        .rst_n         (rst_n),
        .in_valid      (in_valid),
        .in_sof        (in_sof),
        .in_sol        (in_sol),
        .in_data       (in_data),
        .cfg_black_sub (cfg_black_sub),
        .cfg_gain      (cfg_gain),
        .cfg_tp_mode   (cfg_tp_mode),
        .cfg_tp_value  (cfg_tp_value),
        .mid_valid     (mid_valid),
        .mid_sof       (mid_sof),
        .mid_data      (mid_data)
    );

    pc_back #(.DW(DW)) u_back (
        .clk           (clk),
        .rst_n         (rst_n),
        .corr_valid    (corr_valid),
        .corr_sof      (corr_sof),
        .corr_data     (corr_data),
        .cfg_black_add (cfg_black_add),
        .out_valid     (out_valid),
        .out_sof       (out_sof),
        .out_data      (out_data)
    );
endmodule

// File: rtl/pc_cond_chk.sv
module pc_cond_chk #(
    parameter int DW    = 10,
    parameter int GW    = 9,
    parameter int GFRAC = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          in_sof,
    input logic [DW-1:0] in_data,
    input logic [DW-1:0] cfg_black_sub,
    input logic [GW-1:0] cfg_gain,
    input logic [DW-1:0] cfg_black_add,
    input logic [1:0]    cfg_tp_mode,
    input logic [DW-1:0] cfg_tp_value,
    input logic          mid_valid,
    input logic [DW-1:0] mid_data,
    input logic          corr_valid,
    input logic          corr_sof,
    input logic [DW-1:0] corr_data,
    input logic          out_valid,
    input logic          out_sof,
    input logic [DW-1:0] out_data
);
    localparam logic [DW:0]   MAXW = (DW+1)'((1 << DW) - 1);
    localparam logic [DW-1:0] MAXV = DW'((1 << DW) - 1);
    localparam logic [GW-1:0] GONE = GW'(1 << GFRAC);

    logic front_load;
    assign front_load = in_valid && in_sof;

    AST_MID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> mid_valid); // R7
    AST_MID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !mid_valid); // R7
    AST_SUB_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
        (front_load && cfg_tp_mode == 2'd0 && in_data <= cfg_black_sub) |=> mid_data == '0); // R2
    AST_UNITY_GAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (front_load && cfg_tp_mode == 2'd0 && cfg_black_sub == '0 && cfg_gain <= GONE)
        |=> mid_data == $past(in_data)); // R4
    AST_SOLID_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (front_load && cfg_tp_mode == 2'd2) |=> mid_data == $past(cfg_tp_value)); // R5
    AST_OUT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        corr_valid |=> (out_valid && out_sof == $past(corr_sof))); // R8
    AST_OUT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        (corr_valid && corr_sof && ({1'b0, corr_data} + {1'b0, cfg_black_add}) >= MAXW)
        |=> out_data == MAXV); // R8
endmodule

bind pc_cond pc_cond_chk #(.DW(DW), .GW(GW), .GFRAC(GFRAC)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .in_sof        (in_sof),
    .in_data       (in_data),
    .cfg_black_sub (cfg_black_sub),
    .cfg_gain      (cfg_gain),
    .cfg_black_add (cfg_black_add),
    .cfg_tp_mode   (cfg_tp_mode),
    .cfg_tp_value  (cfg_tp_value),
    .mid_valid     (mid_valid),
    .mid_data      (mid_data),
    .corr_valid    (corr_valid),
    .corr_sof      (corr_sof),
    .corr_data     (corr_data),
    .out_valid     (out_valid),
    .out_sof       (out_sof),
    .out_data      (out_data)
);

// File: tb/pc_cond_tb.sv
module pc_cond_tb;
    localparam int CLK_PERIOD = 10;
    localparam int QN = 16384;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0, in_sof = 1'b0, in_sol = 1'b0;
    logic [9:0] in_data = '0;
    logic [9:0] cfg_black_sub = '0, cfg_black_add = '0, cfg_tp_value = '0;
    logic [8:0] cfg_gain = 9'd32;
    logic [1:0] cfg_tp_mode = 2'd0;
    logic       mid_valid, mid_sof, corr_valid, corr_sof, out_valid, out_sof;
    logic [9:0] mid_data, corr_data, out_data;

    assign corr_valid = mid_valid;
    assign corr_sof   = mid_sof;
    assign corr_data  = mid_data;

    always #(CLK_PERIOD/2) clk = ~clk;

    pc_cond u_dut (.*);

    int    n_vec = 0, n_bad = 0;
    int    exp_q [QN];
    bit    sof_q [QN];
    string tag_q [QN];
    int    wr = 0, rd = 0;
    bit    prev_vld = 1'b0;
    int    m_bs = 0, m_g = 32, m_tp = 0, m_tpv = 0, m_add = 0, colc = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int scale(int d);
        int s, g, v;
        s = (d > m_bs) ? d - m_bs : 0;
        g = (m_g < 32) ? 32 : ((m_g > 256) ? 256 : m_g);
        v = (s * g) >> 5;
        return (v > 1023) ? 1023 : v;
    endfunction

    task automatic send(input int d, input bit sof, input bit sol, input string tag);
        int col, v;
        @(negedge clk);
        check(mid_valid == prev_vld, "R7", int'(mid_valid), int'(prev_vld));
        if (sof) begin
            m_bs = cfg_black_sub; m_g = cfg_gain; m_tp = cfg_tp_mode;
            m_tpv = cfg_tp_value; m_add = cfg_black_add;
        end
        col  = sol ? 0 : colc;
        colc = (col + 1) % 1024;
        case (m_tp)
            1: v = col;
            2: v = m_tpv;
            3: v = 1023 - col;
            default: v = scale(d);
        endcase
        v = v + m_add;
        if (v > 1023) v = 1023;
        exp_q[wr] = v; sof_q[wr] = sof; tag_q[wr] = tag; wr++;
        in_valid = 1'b1; in_data = 10'(d); in_sof = sof; in_sol = sol;
        prev_vld = 1'b1;
    endtask

    task automatic idle();
        @(negedge clk);
        check(mid_valid == prev_vld, "R7", int'(mid_valid), int'(prev_vld));
        in_valid = 1'b0; in_sof = 1'b0; in_sol = 1'b0;
        prev_vld = 1'b0;
    endtask

    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (rd >= wr) begin
                check(1'b0, "R8", 1, 0);
            end else begin
                check(int'(out_data) == exp_q[rd], tag_q[rd], int'(out_data), exp_q[rd]);
                check(out_sof == sof_q[rd], "R8", int'(out_sof), int'(sof_q[rd]));
                rd++;
            end
        end
    end

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int gains [9] = '{0, 16, 32, 45, 100, 255, 256, 300, 511};
        int blks [3]  = '{0, 37, 600};
        int adds [3]  = '{0, 5, 900};
        string t;
        repeat (3) @(negedge clk);
        check(mid_valid == 1'b0, "R1", int'(mid_valid), 0);
        check(out_valid == 1'b0, "R1", int'(out_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(mid_valid == 1'b0, "R1", int'(mid_valid), 0);
        check(out_valid == 1'b0, "R1", int'(out_valid), 0);

        // R9: no frame start seen yet, added level must be zero
        cfg_black_add = 10'd77;
        for (int d = 0; d < 1024; d += 97) send(d, 1'b0, 1'b0, "R9");
        idle();

        // R2 R3 R4 R8: sweep black, gain and added level
        for (int b = 0; b < 3; b++) begin
            for (int g = 0; g < 9; g++) begin
                cfg_black_sub = 10'(blks[b]);
                cfg_gain      = 9'(gains[g]);
                cfg_black_add = 10'(adds[(b + g) % 3]);
                for (int d = 0; d < 1024; d += 5) begin
                    if (gains[g] < 32 || gains[g] > 256) t = "R4";
                    else if (d <= blks[b])               t = "R2";
                    else if (adds[(b + g) % 3] != 0)     t = "R8";
                    else                                 t = "R3";
                    send(d, d == 0, d == 0, t);
                end
                idle();
            end
        end

        // R5: ramp with wrap past 1024 and restart on line start
        cfg_tp_mode = 2'd1; cfg_black_add = '0; cfg_gain = 9'd64;
        for (int i = 0; i < 1030; i++) send(i * 3 % 1024, i == 0, i == 0, "R5");
        for (int i = 0; i < 20; i++) send(500, 1'b0, i == 0, "R5");
        idle();
        cfg_tp_mode = 2'd3;
        for (int i = 0; i < 40; i++) send(i, i == 0, i == 0 || i == 25, "R5");
        idle();
        cfg_tp_mode = 2'd2; cfg_tp_value = 10'd613; cfg_black_add = 10'd3;
        for (int i = 0; i < 30; i++) send(i * 37 % 1024, i == 0, i == 0, "R5");
        idle();

        // R6: mid-frame changes must not take hold until the next frame start
        cfg_tp_mode = 2'd0; cfg_black_sub = 10'd100; cfg_gain = 9'd64; cfg_black_add = 10'd10;
        send(400, 1'b1, 1'b1, "R6");
        send(120, 1'b0, 1'b0, "R6");
        idle();
        cfg_black_sub = '0; cfg_gain = 9'd32; cfg_tp_mode = 2'd2; cfg_black_add = 10'd300;
        for (int d = 0; d < 1024; d += 31) send(d, 1'b0, 1'b0, "R6");
        idle();
        for (int d = 0; d < 200; d += 9) send(d, d == 0, d == 0, "R6");
        idle();

        repeat (5) idle();
        check(rd == wr, "R8", rd, wr);
        finish_run();
    end
endmodule